// File: doc/BRIEF.md
# Byte-Wide Nonvolatile Memory Access Controller

This block connects a processor's synchronous register port to a byte-wide nonvolatile data array of 1024 locations. Software reaches the array through four registers: the low byte of the address, the high bits of the address, a data byte, and a control byte. Reading is a single strobe. The selected byte is copied into the data register, and the controller raises a stall output toward the processor for a fixed number of cycles.

Writing is guarded by an unlock sequence. Software first sets an arming bit in the control register. That bit clears itself after a short window. A write strobe is accepted only while the arming bit is still set, and a strobe at any other time does nothing. While a write is in progress, the write strobe bit reads back as one. It clears after a programmable busy time, and at that point a single-cycle completion pulse is raised.

The array is a behavioural memory with one synchronous write port and one synchronous read port. The address register has no defined value after reset, so software must load it before the first access.

Top module: `nvm_access_ctrl`

## Requirements
- R1: Every byte address from 0 to 1023 can be written and then read back intact. The address is formed from the address-low register (select 0, bits 7:0) and the address-high register (select 1, its bits 1:0 giving address bits 9:8).
- R2: Register selects and bit positions:
  - Select 2 is the data byte.
  - Select 3 is the control byte, with bit 0 = read strobe, bit 1 = write strobe / busy, bit 2 = arming bit. Its other bits read as 0.
  - After the synchronous reset, the control byte reads 0 and both the stall and completion outputs are low.
- R3: Writing a one to control bit 2 sets the arming bit. It reads back as one for exactly 4 cycles and then returns to zero with no further action.
- R4: A write strobe (control bit 1) is accepted on any of the 4 clock edges that follow the edge that set the arming bit. An accepted strobe stores the data byte at the current address and clears the arming bit at once.
- R5: A write strobe issued while the arming bit is zero is ignored. Busy stays low and the stored byte keeps its old value.
- R6: After an accepted write strobe, control bit 1 reads as one for exactly 16 cycles (the parameter WR_CYC) and then as zero. The completion output is high for one cycle only: the first cycle in which bit 1 reads zero.
- R7: Setting the arming bit again while it is still set restarts the 4-cycle window from the new setting.
- R8: While a write is busy, the following have no effect:
  - writes to the address or data registers;
  - a read strobe, which raises no stall and loads no data.
- R9: A read strobe copies the byte at the current address into the data register, where it can be read from the second edge after the strobe onward. Control bit 0 always reads as zero.
- R10: An accepted read strobe drives the stall output high for exactly 4 consecutive cycles, starting in the cycle after the strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register select: 0 address low, 1 address high, 2 data, 3 control |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| cpu_stall | output | 1 | Stall request toward the processor after a read strobe |
| wr_done | output | 1 | One-cycle pulse when a write's busy time ends |

## Verification
The bench tests the edges of the arming window directly:
- A strobe on the fourth edge after arming must be taken. Refusing it means the window is one cycle short.
- A strobe on the fifth edge must be refused. Taking it means the window leaks and writes slip through without the unlock.
- A re-arm must extend the window. A controller that does not restart its timer would drop that write.

Busy is measured to the exact cycle, and so is the completion pulse, which an off-by-one counter would shift. Address, data and read-strobe accesses made during a busy write are checked for having no effect, since letting them through would corrupt the write in flight. A sweep over all 1024 addresses with arithmetic patterns exposes any dropped or aliased address bits.

// File: rtl/nvm_pkg.sv
`timescale 1ns/1ps
package nvm_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR_LO = 2'd0,
    SEL_ADDR_HI = 2'd1,
    SEL_DATA    = 2'd2,
    SEL_CTRL    = 2'd3
  } reg_sel_e;

  localparam int CTRL_RD  = 0;
  localparam int CTRL_WR  = 1;
  localparam int CTRL_ARM = 2;
endpackage

// File: rtl/nvm_arm_timer.sv
`timescale 1ns/1ps
module nvm_arm_timer #(
  parameter int ARM_WIN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic arm_o
);
  localparam int CW = $clog2(ARM_WIN + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_o <= 1'b0;
      cnt_q <= '0;
    end else if (clr_i) begin
      arm_o <= 1'b0;
      cnt_q <= '0;
    end else if (set_i) begin
      arm_o <= 1'b1;
      cnt_q <= CW'(ARM_WIN - 1);
    end else if (arm_o) begin
      if (cnt_q == '0) arm_o <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/nvm_write_timer.sv
`timescale 1ns/1ps
module nvm_write_timer #(
  parameter int WR_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(WR_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= (cnt_q == CW'(1));
      if (start_i)           cnt_q <= CW'(WR_CYC);
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/nvm_byte_store.sv
`timescale 1ns/1ps
module nvm_byte_store #(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_q
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_addr];
  end
endmodule

// File: rtl/nvm_access_ctrl.sv
`timescale 1ns/1ps
module nvm_access_ctrl
  import nvm_pkg::*;
#(
  parameter int DEPTH     = 1024,
  parameter int ARM_WIN   = 4,
  parameter int WR_CYC    = 16,
  parameter int STALL_CYC = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] reg_sel,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       cpu_stall,
  output logic       wr_done
);
  localparam int AW  = $clog2(DEPTH);
  localparam int HW  = AW - 8;
  localparam int SCW = $clog2(STALL_CYC + 1);

  logic          arm;
  logic          busy;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic [7:0]    rd_q;
  logic          rd_pend_q;
  logic [SCW-1:0] stall_cnt_q;

  logic ctrl_wr, wr_start, rd_start, arm_set;

  always_comb begin
    ctrl_wr  = reg_we && (reg_sel == SEL_CTRL);
    wr_start = ctrl_wr && reg_wdata[CTRL_WR] && arm && !busy;
    arm_set  = ctrl_wr && reg_wdata[CTRL_ARM];
    rd_start = ctrl_wr && reg_wdata[CTRL_RD] && !busy && !wr_start;
  end

  nvm_arm_timer #(.ARM_WIN(ARM_WIN)) u_arm (
    .clk   (clk),
    .rst   (rst),
    .set_i (arm_set),
    .clr_i (wr_start),
    .arm_o (arm)
  );

  nvm_write_timer #(.WR_CYC(WR_CYC)) u_wtmr (
    .clk     (clk),
    .rst     (rst),
    .start_i (wr_start),
    .busy_o  (busy),
    .done_o  (wr_done)
  );

  nvm_byte_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk     (clk),
    .wr_en   (wr_start),
    .wr_addr (addr_q),
    .wr_data (data_q),
    .rd_en   (rd_start),
    .rd_addr (addr_q),
    .rd_q    (rd_q)
  );

  // Address register: deliberately left without reset.
  always_ff @(posedge clk) begin
    if (reg_we && !busy) begin
      if (reg_sel == SEL_ADDR_LO) addr_q[7:0]    <= reg_wdata;
      if (reg_sel == SEL_ADDR_HI) addr_q[AW-1:8] <= reg_wdata[HW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q    <= 8'h00;
      rd_pend_q <= 1'b0;
    end else begin
      rd_pend_q <= rd_start;
      if (rd_pend_q)                                     data_q <= rd_q;
      else if (reg_we && !busy && reg_sel == SEL_DATA)   data_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                     stall_cnt_q <= '0;
    else if (rd_start)           stall_cnt_q <= SCW'(STALL_CYC);
    else if (stall_cnt_q != '0)  stall_cnt_q <= stall_cnt_q - 1'b1;
  end

  assign cpu_stall = (stall_cnt_q != '0);

  logic [15:0] addr_ext;
  assign addr_ext = 16'(addr_q);

  always_comb begin
    unique case (reg_sel)
      SEL_ADDR_LO: reg_rdata = addr_ext[7:0];
      SEL_ADDR_HI: reg_rdata = addr_ext[15:8];
      SEL_DATA:    reg_rdata = data_q;
      default:     reg_rdata = {5'b0, arm, busy, 1'b0};
    endcase
  end
endmodule

// File: rtl/nvm_access_ctrl_chk.sv
`timescale 1ns/1ps
module nvm_access_ctrl_chk #(
  parameter int AW        = 10,
  parameter int ARM_WIN   = 4,
  parameter int WR_CYC    = 16,
  parameter int STALL_CYC = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    reg_sel,
  input logic          reg_we,
  input logic [7:0]    reg_wdata,
  input logic          cpu_stall,
  input logic          wr_done,
  input logic          arm,
  input logic          busy,
  input logic [AW-1:0] addr_q
);
  logic ctl_w;
  assign ctl_w = reg_we && (reg_sel == 2'd3);

  int arm_run, busy_run, stall_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_run <= 0; busy_run <= 0; stall_run <= 0;
    end else begin
      arm_run   <= (ctl_w && reg_wdata[2]) ? 0 : (arm ? arm_run + 1 : 0);
      busy_run  <= busy ? busy_run + 1 : 0;
      stall_run <= cpu_stall ? stall_run + 1 : 0;
    end
  end

  // R3
  arm_window_chk: assert property (@(posedge clk) disable iff (rst)
    arm |-> (arm_run < ARM_WIN));

  // R4
  arm_consumed_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_w && reg_wdata[1] && arm && !busy) |=> (busy && !arm));

  // R5
  no_unarmed_write_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_w && reg_wdata[1] && !arm && !busy) |=> !busy);

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (busy_run < WR_CYC));

  // R6
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    wr_done |-> ($past(busy) && !busy));

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(addr_q));

  // R10
  stall_start_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_w && reg_wdata[0] && !reg_wdata[1] && !busy) |=> cpu_stall);

  // R10
  stall_len_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_stall |-> (stall_run < STALL_CYC));
endmodule

bind nvm_access_ctrl nvm_access_ctrl_chk #(
  .AW(AW), .ARM_WIN(ARM_WIN), .WR_CYC(WR_CYC), .STALL_CYC(STALL_CYC)
) u_chk (
  .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .cpu_stall(cpu_stall), .wr_done(wr_done),
  .arm(arm), .busy(busy), .addr_q(addr_q)
);

// File: tb/nvm_access_ctrl_bench.sv
`timescale 1ns/1ps
module nvm_access_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] reg_sel = 2'd0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       cpu_stall, wr_done;

  int tests = 0;
  int fails = 0;
  logic [7:0] exp_mem [1024];

  always #2 clk = ~clk;

  nvm_access_ctrl u_nvm_access_ctrl (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_stall(cpu_stall), .wr_done(wr_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk);
    #1 reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk);
    reg_sel = s;
    #1 d = reg_rdata;
  endtask

  task automatic set_addr(input int a);
    wr(2'd0, 8'(a));
    wr(2'd1, 8'(a >> 8));
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int g = 0; g < 64; g++) begin
      rd(2'd3, v);
      if (!v[1]) break;
    end
  endtask

  task automatic do_write(input int a, input logic [7:0] d);
    set_addr(a);
    wr(2'd2, d);
    wr(2'd3, 8'h04);
    wr(2'd3, 8'h02);
    exp_mem[a] = d;
    wait_idle();
  endtask

  task automatic do_read(input int a, output logic [7:0] d);
    set_addr(a);
    wr(2'd3, 8'h01);
    repeat (5) @(posedge clk);
    rd(2'd2, d);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;

    // R2 reset state
    rd(2'd3, v);
    chk("R2 ctrl after reset", v, 0);
    chk("R2 stall after reset", cpu_stall, 0);
    chk("R2 done after reset", wr_done, 0);

    // R3 arming bit lifetime
    set_addr(5);
    wr(2'd3, 8'h04);
    for (int i = 0; i < 6; i++) begin
      rd(2'd3, v);
      chk("R3 arm readback", v[2], (i < 4) ? 1 : 0);
    end

    // R4 / R6 full write with exact busy length and done pulse
    wr(2'd2, 8'hA5);
    wr(2'd3, 8'h04);
    wr(2'd3, 8'h02);
    exp_mem[5] = 8'hA5;
    n = 0;
    for (int i = 0; i < 40; i++) begin
      rd(2'd3, v);
      if (i == 0) chk("R4 arm cleared by strobe", v[2], 0);
      if (v[1]) n++;
      else begin
        chk("R6 done pulse at busy end", wr_done, 1);
        break;
      end
    end
    chk("R6 busy cycles", n, 16);
    @(negedge clk);
    chk("R6 done is one cycle", wr_done, 0);

    // R4 strobe on the last edge of the window
    do_write(7, 8'h11);
    set_addr(6);
    wr(2'd2, 8'h3C);
    wr(2'd3, 8'h04);
    repeat (3) @(posedge clk);
    wr(2'd3, 8'h02);
    rd(2'd3, v);
    chk("R4 last-edge strobe accepted", v[1], 1);
    exp_mem[6] = 8'h3C;
    wait_idle();

    // R5 strobe one edge after the window
    set_addr(7);
    wr(2'd2, 8'hEE);
    wr(2'd3, 8'h04);
    repeat (4) @(posedge clk);
    wr(2'd3, 8'h02);
    rd(2'd3, v);
    chk("R5 late strobe ignored", v[1], 0);
    // R5 strobe with no arming at all
    wr(2'd3, 8'h02);
    rd(2'd3, v);
    chk("R5 unarmed strobe ignored", v[1], 0);
    do_read(7, v);
    chk("R5 byte unchanged", v, 8'h11);

    // R7 re-arm restarts the window
    set_addr(8);
    wr(2'd2, 8'h77);
    wr(2'd3, 8'h04);
    repeat (2) @(posedge clk);
    wr(2'd3, 8'h04);
    repeat (3) @(posedge clk);
    wr(2'd3, 8'h02);
    rd(2'd3, v);
    chk("R7 re-armed strobe accepted", v[1], 1);
    exp_mem[8] = 8'h77;
    wait_idle();

    // R8 accesses during busy are ignored
    set_addr(9);
    wr(2'd2, 8'h55);
    wr(2'd3, 8'h04);
    wr(2'd3, 8'h02);
    exp_mem[9] = 8'h55;
    wr(2'd0, 8'hF0);
    wr(2'd2, 8'h0F);
    wr(2'd3, 8'h01);
    #1 chk("R8 no stall from busy read", cpu_stall, 0);
    rd(2'd0, v);
    chk("R8 address held", v, 8'h09);
    rd(2'd2, v);
    chk("R8 data held", v, 8'h55);
    wait_idle();

    // R10 / R9 read strobe
    set_addr(5);
    wr(2'd3, 8'h01);
    n = 0;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      if (cpu_stall) n++;
    end
    chk("R10 stall cycles", n, 4);
    rd(2'd2, v);
    chk("R9 read data", v, 8'hA5);
    rd(2'd3, v);
    chk("R9 read strobe reads zero", v[0], 0);
    for (int a = 6; a < 10; a++) begin
      do_read(a, v);
      chk("R9 readback", v, exp_mem[a]);
    end

    // R1 sweep of every address
    for (int a = 0; a < 1024; a++)
      do_write(a, 8'((a * 37) + (a >> 3) + 1));
    for (int a = 0; a < 1024; a++) begin
      do_read(a, v);
      chk("R1 sweep readback", v, exp_mem[a]);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule